// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a behavioural model of a synchronous static memory whose read and write pipelines share one timing. Every command takes its bus data cycle at the same distance from the edge that accepted it. As a result, reads and writes may follow each other on consecutive clock edges with no idle cycle between them. The data word is split into byte lanes. Each write carries a lane mask. A write whose mask is empty becomes a write abort. A read issued while output enable is low becomes a dummy read.

Each enabled clock edge decodes one command from the select, advance, write, lane-enable and sleep inputs. A new burst loads the external address. A continue cycle steps a four-beat burst address sequencer in linear or interleaved order and repeats the kind of the burst in progress. A hold input freezes the whole block for that edge. Output enable gates the bus drive combinationally. A sleep input forces the block into a deselected, non-driving state.

Top module: `zbt_sram_pipe`

## Requirements
- R1: While reset is active, and after it is released, the bus is not driven (`rdata_oe` low) regardless of `oe`, and the burst state is deselected.
- R2: With `adv` low and `sel` low, the cycle is a deselect and nothing is driven in its data cycle. With `adv` high after a deselect, the block stays deselected.
- R3: With `sel` high, `adv` low and `wr` low, a read of `addr` is accepted. Its word is driven on `rdata` in the cycle after the next enabled edge and is held until the edge after that.
- R4: With `adv` high during a read or write burst, the burst continues at the next beat. `sel` is ignored, and so is `wr` in a read burst. Beat n of a burst that starts at address S keeps the upper address bits of S. The two low bits are (S+n) mod 4 when `linear` was high at the load, or S XOR n when it was low. `linear` is sampled only at the load.
- R5: With `sel` high, `adv` low and `wr` high, a write of `addr` is accepted. `wdata` is sampled at the second enabled edge after it. Bit i of `lane_en` enables data bits 8i+7 to 8i, and only enabled lanes change.
- R6: A write whose lane mask is all zero changes no memory word and drives nothing.
- R7: During the data cycle of any write, the bus is not driven even when `oe` is high.
- R8: `rdata_oe` equals "data cycle of a read, `oe` high and `sleep` low" combinationally, without waiting for a clock edge.
- R9: With `hold` high, an edge is ignored. The command, pipeline, burst position, memory and bus state are all held.
- R10: With `sleep` high, the edge accepts no command, a write reaching its data edge is blocked, and the bus is not driven. After release, a continue cycle stays deselected.
- R11: Reads and writes may alternate on consecutive edges. A read accepted one edge after a write to the same address returns the newly written lanes.
- R12: A read issued with `oe` low drives nothing, yet it still advances the pipeline and the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 = ignore this edge (wait state) |
| sleep | input | 1 | 1 = forced deselect, bus off, writes blocked |
| sel | input | 1 | 1 = block selected for a new burst |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| wr | input | 1 | 1 = write, 0 = read, on a load |
| lane_en | input | LANES | Per-byte write enables |
| linear | input | 1 | Burst order on load: 1 linear, 0 interleaved |
| oe | input | 1 | Asynchronous output enable, active high |
| addr | input | ADDR_W | External word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rdata_oe | output | 1 | Bus drive enable (0 = tri-stated) |

## Verification
The bench builds the block with `ADDR_W`=6, `DATA_W`=32, `LANES`=4 and `BURST_W`=2. This gives 64 words, which is small enough to fill every address with a distinct pattern before any read, so that each read and each burst beat is identified by its value. The 2-bit burst reaches its wrap point in four beats. Starting a burst at an odd offset makes the linear and interleaved orders differ, so each order can be told apart.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } bstate_e;
endpackage

// File: rtl/zbt_cycle_fsm.sv
module zbt_cycle_fsm
    import zbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic sleep,
    input  logic sel,
    input  logic adv,
    input  logic wr,
    output op_e  cmd_op,
    output logic cmd_load,
    output logic cmd_step
);
    bstate_e state, nxt;

    // state register: frozen on held edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (!hold)
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (sleep)
            nxt = ST_SLEEP;
        else if (!adv)
            nxt = !sel ? ST_IDLE : (wr ? ST_WRITE : ST_READ);
        else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_READ:  nxt = ST_READ;
                ST_WRITE: nxt = ST_WRITE;
                ST_SLEEP: nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_load = !sleep && !adv && sel;
        cmd_step = !sleep && adv && (state == ST_READ || state == ST_WRITE);
        unique case (nxt)
            ST_READ:  cmd_op = OP_READ;
            ST_WRITE: cmd_op = OP_WRITE;
            default:  cmd_op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic              step,
    input  logic              linear,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nxt;
    logic [BURST_W-1:0] offs;
    logic               lin_q;

    assign cnt_nxt = cnt_q + BURST_W'(1);

    generate
        if (BURST_W > 0) begin : g_order
            assign offs = lin_q ? (base_q[BURST_W-1:0] + cnt_nxt)
                                : (base_q[BURST_W-1:0] ^ cnt_nxt);
        end
    endgenerate

    assign cur_addr = load ? ext_addr : {base_q[ADDR_W-1:BURST_W], offs};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b0;
        end else if (!hold) begin
            if (load) begin
                base_q <= ext_addr;
                cnt_q  <= '0;
                lin_q  <= linear;
            end else if (step) begin
                cnt_q  <= cnt_nxt;
            end
        end
    end
endmodule

// File: rtl/zbt_lane_store.sv
module zbt_lane_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int LW    = DATA_W / LANES;
    localparam int DEPTH = 1 << ADDR_W;

    logic same_word;
    assign same_word = wr_en && (wr_addr == rd_addr);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LW-1:0] mem [DEPTH];
            logic [LW-1:0] lane_q;
            logic [LW-1:0] lane_in;

            assign lane_in = wdata[g*LW +: LW];

            always_ff @(posedge clk) begin
                if (!hold && wr_en && wr_lanes[g])
                    mem[wr_addr] <= lane_in;
            end

            // a write landing on the same edge is forwarded lane by lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    lane_q <= '0;
                else if (!hold && rd_en)
                    lane_q <= (same_word && wr_lanes[g]) ? lane_in : mem[rd_addr];
            end

            assign rdata_q[g*LW +: LW] = lane_q;
        end
    endgenerate
endmodule

// File: rtl/zbt_sram_pipe.sv
module zbt_sram_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sleep,
    input  logic              sel,
    input  logic              adv,
    input  logic              wr,
    input  logic [LANES-1:0]  lane_en,
    input  logic              linear,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    op_e               cmd_op;
    logic              cmd_load;
    logic              cmd_step;
    logic [ADDR_W-1:0] cur_addr;

    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_lanes, s2_lanes;
    logic              drive_q;
    logic [DATA_W-1:0] rd_q;

    zbt_cycle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .sleep    (sleep),
        .sel      (sel),
        .adv      (adv),
        .wr       (wr),
        .cmd_op   (cmd_op),
        .cmd_load (cmd_load),
        .cmd_step (cmd_step)
    );

    zbt_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .load     (cmd_load),
        .step     (cmd_step),
        .linear   (linear),
        .ext_addr (addr),
        .cur_addr (cur_addr)
    );

    // two-stage command pipeline shared by reads and writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op    <= OP_NONE;
            s2_op    <= OP_NONE;
            s1_addr  <= '0;
            s2_addr  <= '0;
            s1_lanes <= '0;
            s2_lanes <= '0;
            drive_q  <= 1'b0;
        end else if (!hold) begin
            s1_op    <= cmd_op;
            s1_addr  <= cur_addr;
            s1_lanes <= lane_en;
            s2_op    <= s1_op;
            s2_addr  <= s1_addr;
            s2_lanes <= s1_lanes;
            drive_q  <= (s1_op == OP_READ);
        end
    end

    zbt_lane_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .rd_en    (s1_op == OP_READ),
        .rd_addr  (s1_addr),
        .wr_en    ((s2_op == OP_WRITE) && !sleep),
        .wr_addr  (s2_addr),
        .wr_lanes (s2_lanes),
        .wdata    (wdata),
        .rdata_q  (rd_q)
    );

    assign rdata    = rd_q;
    assign rdata_oe = drive_q && oe && !sleep;
endmodule

// File: rtl/zbt_sram_pipe_chk.sv
module zbt_sram_pipe_chk
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              sleep,
    input logic              sel,
    input logic              adv,
    input logic              wr,
    input logic              oe,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input op_e               s1_op,
    input op_e               s2_op,
    input logic [ADDR_W-1:0] s1_addr,
    input logic              drive_q
);
    a_r2_deselect_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !sleep && !sel && !adv) |=> (s1_op == OP_NONE));

    a_r3_read_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !sleep && sel && !adv && !wr) |=> (s1_op == OP_READ && s1_addr == $past(addr)));

    a_r7_write_cycle_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_op == OP_WRITE) |-> !rdata_oe);

    a_r8_oe_gates_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !rdata_oe);

    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(rdata) && $stable(drive_q)));

    a_r10_sleep_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_oe);

    a_r10_sleep_no_command: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !hold) |=> (s1_op == OP_NONE));
endmodule

bind zbt_sram_pipe zbt_sram_pipe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .sleep    (sleep),
    .sel      (sel),
    .adv      (adv),
    .wr       (wr),
    .oe       (oe),
    .addr     (addr),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .s1_op    (s1_op),
    .s2_op    (s2_op),
    .s1_addr  (s1_addr),
    .drive_q  (drive_q)
);

// File: tb/zbt_sram_pipe_test.sv
`timescale 1ns/1ps
module zbt_sram_pipe_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0, sleep = 1'b0, sel = 1'b0, adv = 1'b0, wr = 1'b0;
    logic [3:0]  lane_en = 4'h0;
    logic        linear = 1'b0, oe = 1'b1;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdata_oe;

    always #10 clk = ~clk;

    zbt_sram_pipe #(.ADDR_W(6), .DATA_W(32), .LANES(4), .BURST_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sleep(sleep), .sel(sel), .adv(adv),
        .wr(wr), .lane_en(lane_en), .linear(linear), .oe(oe), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    typedef struct { int kind; logic [5:0] a; logic [3:0] ln; logic [31:0] d; } cmd_s;
    typedef struct { int e; logic [31:0] d; } exp_s;

    int    checks = 0, failures = 0, en_edges = 0, seen = -1;
    string cur_req = "R1";
    logic [31:0] mmem [64];
    exp_s  q[$];
    cmd_s  p1 = '{0, 6'd0, 4'd0, 32'd0};
    cmd_s  p2 = '{0, 6'd0, 4'd0, 32'd0};
    int    bkind = 0, bn = 0;
    logic [5:0] bstart = '0;
    bit    blin = 0;
    bit    cur_drv = 0;
    logic [31:0] cur_dat = '0;
    bit    done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] seq(input logic [5:0] s, input int n, input bit lin);
        logic [1:0] o;
        o = lin ? (s[1:0] + 2'(n)) : (s[1:0] ^ 2'(n));
        return {s[5:2], o};
    endfunction

    // driver: called just after a rising edge; models the expected result
    task automatic cyc(input bit h, input bit slp, input bit s, input bit a, input bit w,
                       input logic [3:0] ln, input logic [5:0] ad, input logic [31:0] nd, input bit lin);
        cmd_s nc;
        hold = h; sleep = slp; sel = s; adv = a; wr = w; lane_en = ln; addr = ad; linear = lin;
        wdata = (p2.kind == 2) ? p2.d : 32'hBAD0_0000 ^ 32'(en_edges);
        @(posedge clk); #1;
        if (!h) begin
            en_edges++;
            if (p2.kind == 2 && !slp)
                for (int i = 0; i < 4; i++)
                    if (p2.ln[i]) mmem[p2.a][i*8 +: 8] = p2.d[i*8 +: 8];
            if (p1.kind == 1) q.push_back('{en_edges, mmem[p1.a]});
            nc.ln = ln; nc.d = nd; nc.a = ad; nc.kind = 0;
            if (slp) bkind = 0;
            else if (!a) begin
                nc.kind = s ? (w ? 2 : 1) : 0;
                bkind = nc.kind; bstart = ad; bn = 0; blin = lin;
            end else if (bkind != 0) begin
                bn++;
                nc.kind = bkind;
                nc.a = seq(bstart, bn, blin);
            end
            p2 = p1; p1 = nc;
        end
    endtask

    task automatic rd(input logic [5:0] a);  cyc(0,0,1,0,0,4'h0,a,32'h0,0); endtask
    task automatic wrc(input logic [5:0] a, input logic [3:0] ln, input logic [31:0] d); cyc(0,0,1,0,1,ln,a,d,0); endtask
    task automatic nop();                    cyc(0,0,0,0,0,4'h0,6'h0,32'h0,0); endtask
    task automatic cont(input logic [31:0] d, input logic [3:0] ln); cyc(0,0,0,1,1,ln,6'h3F,d,0); endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit expo;
            if (en_edges != seen) begin
                seen = en_edges;
                cur_drv = 0;
                if (q.size() > 0 && q[0].e == en_edges) begin
                    cur_drv = 1;
                    cur_dat = q[0].d;
                    void'(q.pop_front());
                end
            end
            expo = cur_drv && oe && !sleep;
            chk(rdata_oe == expo, {cur_req, " bus enable"}, 32'(rdata_oe), 32'(expo));
            if (expo) chk(rdata == cur_dat, {cur_req, " read data"}, rdata, cur_dat);
        end
    end

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset with oe high
        repeat (3) @(posedge clk);
        #1;
        chk(rdata_oe == 1'b0, "R1 reset bus", 32'(rdata_oe), 32'h0);
        rst_n = 1'b1;
        #2;
        chk(rdata_oe == 1'b0, "R1 after release", 32'(rdata_oe), 32'h0);

        // R5 fill every word, full lanes
        cur_req = "R5";
        for (int i = 0; i < 64; i++) wrc(6'(i), 4'hF, 32'h1000_0000 + 32'(i) * 32'h0101_0101);
        nop(); nop();

        // R3 single reads
        cur_req = "R3";
        rd(6'd5); rd(6'd63); rd(6'd0); nop(); nop();

        // R4 linear burst from 5: 5,6,7,4 ; linear input changed during continue
        cur_req = "R4";
        cyc(0,0,1,0,0,4'h0,6'd5,0,1);
        for (int i = 0; i < 3; i++) cyc(0,0,0,1,1,4'h0,6'h3F,0,0);
        // interleaved from 5: 5,4,7,6
        cyc(0,0,1,0,0,4'h0,6'd5,0,0);
        for (int i = 0; i < 3; i++) cyc(0,0,1,1,1,4'h0,6'h3F,0,1);
        nop(); nop();

        // R2 deselect then continue
        cur_req = "R2";
        nop(); cyc(0,0,1,1,0,4'h0,6'd9,0,0); cyc(0,0,1,1,0,4'h0,6'd9,0,0); nop(); nop();

        // R6 write abort, then read back unchanged
        cur_req = "R6";
        wrc(6'd2, 4'h0, 32'hDEAD_BEEF); nop(); nop(); rd(6'd2); nop(); nop();

        // R5 partial lanes
        cur_req = "R5";
        wrc(6'd3, 4'b0101, 32'hAABB_CCDD); nop(); nop(); rd(6'd3); nop(); nop();

        // R11 and R7 alternating, same-address forwarding
        cur_req = "R11";
        wrc(6'd40, 4'hF, 32'h4040_4040); rd(6'd40);
        wrc(6'd41, 4'b1100, 32'h4141_4141); rd(6'd41);
        rd(6'd40); wrc(6'd42, 4'hF, 32'h4242_0000); rd(6'd42); wrc(6'd43, 4'hF, 32'h4343_4343);
        nop(); nop();

        // R4 write burst, linear from 10: 10,11,8,9
        cur_req = "R4";
        cyc(0,0,1,0,1,4'hF,6'd10,32'h5100_0000,1);
        cont(32'h5100_0001, 4'hF); cont(32'h5100_0002, 4'h1); cont(32'h5100_0003, 4'hF);
        nop(); nop(); rd(6'd8); rd(6'd9); rd(6'd10); rd(6'd11); nop(); nop();

        // R12 dummy read with oe low, then R8 asynchronous oe
        cur_req = "R12";
        oe = 1'b0; rd(6'd20); nop(); nop(); oe = 1'b1;
        cur_req = "R8";
        rd(6'd21); nop();
        hold = 1'b1;
        oe = 1'b0; #2;
        chk(rdata_oe == 1'b0, "R8 oe low", 32'(rdata_oe), 32'h0);
        oe = 1'b1; #2;
        chk(rdata_oe == 1'b1, "R8 oe high", 32'(rdata_oe), 32'h1);
        chk(rdata == mmem[21], "R8 data", rdata, mmem[21]);

        // R9 hold inside a read burst
        cur_req = "R9";
        cyc(1,0,0,0,0,4'h0,6'h0,0,0);
        cyc(0,0,1,0,0,4'h0,6'd30,0,1);
        cyc(1,0,1,0,1,4'hF,6'd0,32'h0,0);
        cont(0, 4'h0);
        cyc(1,0,1,0,1,4'hF,6'd0,32'h0,0);
        cyc(1,0,1,0,1,4'hF,6'd0,32'h0,0);
        cont(0, 4'h0); nop();
        cyc(1,0,0,0,0,4'h0,6'h0,0,0);
        nop(); nop();

        // R10 sleep blocks a write and bus, continue after release stays idle
        cur_req = "R10";
        wrc(6'd12, 4'hF, 32'h1212_1212); nop();
        cyc(0,1,1,0,1,4'hF,6'd13,32'h0,0);
        cyc(0,0,1,1,0,4'h0,6'd0,0,0);
        nop(); rd(6'd12); rd(6'd13);
        cyc(0,1,0,0,0,4'h0,6'd0,0,0);
        nop(); nop();
        chk(mmem[12] == 32'h1000_0000 + 32'd12 * 32'h0101_0101, "R10 model", mmem[12],
            32'h1000_0000 + 32'd12 * 32'h0101_0101);

        chk(q.size() == 0, "R3 all reads observed", 32'(q.size()), 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule